// File: doc/BRIEF.md
# Programmable-Width Serial Word Assembler

This block turns a serial bit stream into parallel words and marks each finished word with a write strobe for the storage that follows it. Bits are captured on the rising edge of the serial shift clock, least significant bit first. One device holds up to nine bit positions. The positions at the top of its range drive tap outputs, and these taps rise one after another as the word fills. The word ends when a tap, routed back to the `nxt_word` input, goes high. The rising edge after that begins a new word.

The `len_sel` input picks which local tap appears on `word_end_o`. Value 0 picks the bit-7 tap and gives 8-bit words. Value 1 picks the bit-8 tap and gives 9-bit words. A standalone device feeds `word_end_o` back to its own `nxt_word`.

Longer words are built by chaining devices:
- The least significant device has its cascade enable tied high.
- Each later device takes a tap output of the device before it as its cascade enable.
- All devices share one `nxt_word`, driven from the tap of the most significant device.

The write strobe is held back while the storage downstream reports full. In that case the finished word is dropped.

Top module: `sr_word_assembler`

## Requirements
- R1: The bit sampled on the first storing edge of a word appears on `word_o[0]`. Each following stored bit lands one position higher.
- R2: While `rst_n` is low, `tap_o`, `word_end_o` and `wr_stb_o` are all low.
- R3: On the first edge of every word, all bits of `tap_o` go low. `tap_o[k]` rises on the edge that stores bit position 7+k and stays high until the next word begins.
- R4: `word_end_o` follows `tap_o[0]` (the bit-7 position) when `len_sel` is 0, and `tap_o[1]` (the bit-8 position) when `len_sel` is 1.
- R5: The edge after the one where `nxt_word` is seen high starts a new word at bit position 0 and clears every position that is not written in that word. With 8-bit words, `word_o[8]` therefore reads 0.
- R6: `wr_stb_o` is high only in a cycle where `nxt_word` is high and `full_i` is low. It lasts exactly one cycle per word, and `word_o` holds the complete word during that cycle.
- R7: If `full_i` is high while a word completes, no strobe is given for that word. The next word is still assembled and strobed normally.
- R8: Edges at which `casc_en` is low store nothing and leave `word_o` and `tap_o` unchanged. After `casc_en` goes high, storing begins at position 0, and a device stores at most nine bits per word.
- R9: A device whose cascade enable has been seen low ignores the first edge of each word, even though its enable is still high from the previous word. Two such-wired devices with `len_sel` 0 form a 16-bit word, with the second device holding bits 8 to 15 in `word_o[7:0]`.
- R10: Reset is applied asynchronously. Its release takes effect after two rising edges, and the edge after those stores bit 0 of the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial shift clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ser_in | input | 1 | Serial data, least significant bit first |
| casc_en | input | 1 | Cascade enable: tied high, or a tap of the previous device |
| len_sel | input | 1 | Local tap shown on word_end_o: 0 = bit 7, 1 = bit 8 |
| nxt_word | input | 1 | Word-end indication shared by all chained devices |
| full_i | input | 1 | Downstream storage full, suppresses the strobe |
| tap_o | output | 2 | Bit-position taps for positions 7 and 8 |
| word_o | output | 9 | Assembled parallel word |
| word_end_o | output | 1 | Selected local tap, for feedback to nxt_word |
| wr_stb_o | output | 1 | One-cycle word-complete write strobe |

## Verification
All three instances in the bench use the default nine-bit width with taps at positions 7 and 8. Because `len_sel` is driven at run time, one instance covers both the 8-bit and the 9-bit word length, including the upper bit being cleared in 8-bit mode. Two further instances are wired in a chain with a shared word end. This brings within reach the 16-bit word split across devices and the start-edge filtering that only a chained device performs.

// File: rtl/sr_asm_pkg.sv
package sr_asm_pkg;

  // Per-edge control decision passed from the sequencer to the data register
  typedef struct packed {
    logic start;  // this edge begins a new word
    logic store;  // this edge captures the serial bit
  } step_t;

endpackage

// File: rtl/sr_asm_ctrl.sv
module sr_asm_ctrl
  import sr_asm_pkg::*;
#(
  parameter int WORD_BITS = 9,
  parameter int TAP_BASE  = 7,
  localparam int NTAP     = WORD_BITS - TAP_BASE,
  localparam int CNT_W    = $clog2(WORD_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             casc_en,
  input  logic             nxt_word,
  output step_t            step,
  output logic [CNT_W-1:0] pos,
  output logic [NTAP-1:0]  tap_q
);

  logic             fresh_q, fresh_d;
  logic             chained_q, chained_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NTAP-1:0]  tap_d;

  // Next-state logic
  always_comb begin
    step.start = nxt_word | fresh_q;
    if (step.start)
      step.store = casc_en & ~chained_q;
    else
      step.store = casc_en & (cnt_q < CNT_W'(WORD_BITS));

    pos       = step.start ? '0 : cnt_q;
    fresh_d   = 1'b0;
    chained_d = chained_q | ~casc_en;

    if (step.start)
      cnt_d = step.store ? CNT_W'(1) : '0;
    else if (step.store)
      cnt_d = cnt_q + CNT_W'(1);
    else
      cnt_d = cnt_q;

    for (int k = 0; k < NTAP; k++) begin
      if (step.start)
        tap_d[k] = 1'b0;
      else
        tap_d[k] = tap_q[k] | (step.store && (cnt_q == CNT_W'(TAP_BASE + k)));
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q   <= 1'b1;
      chained_q <= 1'b0;
      cnt_q     <= '0;
      tap_q     <= '0;
    end else begin
      fresh_q   <= fresh_d;
      chained_q <= chained_d;
      cnt_q     <= cnt_d;
      tap_q     <= tap_d;
    end
  end

  // R3: a word end is followed by a fresh word with all taps low
  assert_taps_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_word |=> (tap_q == '0));

  // R8: at most WORD_BITS bits are stored per word
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WORD_BITS));

  // R3: taps fill in order, so a higher tap implies every lower one
  generate
    for (genvar k = 1; k < NTAP; k++) begin : g_order
      assert_tap_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tap_q[k] |-> tap_q[k-1]);
    end
  endgenerate

endmodule

// File: rtl/sr_asm_shreg.sv
module sr_asm_shreg
  import sr_asm_pkg::*;
#(
  parameter int WORD_BITS = 9,
  localparam int CNT_W    = $clog2(WORD_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  step_t                step,
  input  logic [CNT_W-1:0]     pos,
  input  logic                 ser_in,
  output logic [WORD_BITS-1:0] word_q
);

  logic [WORD_BITS-1:0] word_d;

  generate
    for (genvar i = 0; i < WORD_BITS; i++) begin : g_bit
      logic bit_en;
      assign bit_en = step.store && (pos == CNT_W'(i));
      always_comb begin
        if (bit_en)
          word_d[i] = ser_in;
        else if (step.start)
          word_d[i] = 1'b0;
        else
          word_d[i] = word_q[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  // R8: an edge that neither stores nor starts a word leaves the data alone
  assert_hold_no_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step.store && !step.start) |=> $stable(word_q));

endmodule

// File: rtl/sr_word_assembler.sv
module sr_word_assembler
  import sr_asm_pkg::*;
#(
  parameter int WORD_BITS = 9,
  parameter int TAP_BASE  = 7,
  localparam int NTAP     = WORD_BITS - TAP_BASE,
  localparam int SEL_W    = (NTAP > 1) ? $clog2(NTAP) : 1,
  localparam int CNT_W    = $clog2(WORD_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_in,
  input  logic                 casc_en,
  input  logic [SEL_W-1:0]     len_sel,
  input  logic                 nxt_word,
  input  logic                 full_i,
  output logic [NTAP-1:0]      tap_o,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 word_end_o,
  output logic                 wr_stb_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  step_t            step;
  logic [CNT_W-1:0] pos;

  // Asynchronous assert, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sr_asm_ctrl #(.WORD_BITS(WORD_BITS), .TAP_BASE(TAP_BASE)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .casc_en  (casc_en),
    .nxt_word (nxt_word),
    .step     (step),
    .pos      (pos),
    .tap_q    (tap_o)
  );

  sr_asm_shreg #(.WORD_BITS(WORD_BITS)) shreg_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .step   (step),
    .pos    (pos),
    .ser_in (ser_in),
    .word_q (word_o)
  );

  // Length select: pick the local tap that marks the word end
  always_comb begin
    word_end_o = 1'b0;
    for (int k = 0; k < NTAP; k++)
      if (len_sel == SEL_W'(k)) word_end_o = tap_o[k];
  end

  assign wr_stb_o = nxt_word & ~full_i;

  // R6: a word-complete strobe never lasts more than one cycle
  assert_stb_single_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_stb_o |=> !wr_stb_o);

endmodule

// File: tb/sr_word_assembler_tb.sv
`timescale 1ns/100ps
module sr_word_assembler_tb_top;

  logic clk = 1'b0;
  logic rst_n, ser_in, casc_en, len_sel, full_i, nxt_word;
  logic [1:0] tap_o;
  logic [8:0] word_o;
  logic word_end_o, wr_stb_o;

  logic [1:0] l_tap, t_tap;
  logic [8:0] l_word, t_word;
  logic l_end, t_end, l_stb, t_stb, c_nxt;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  assign nxt_word = word_end_o;
  assign c_nxt    = t_end;

  sr_word_assembler dut_i (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .casc_en(casc_en),
    .len_sel(len_sel), .nxt_word(nxt_word), .full_i(full_i),
    .tap_o(tap_o), .word_o(word_o), .word_end_o(word_end_o), .wr_stb_o(wr_stb_o)
  );

  sr_word_assembler lead_i (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .casc_en(1'b1),
    .len_sel(1'b0), .nxt_word(c_nxt), .full_i(full_i),
    .tap_o(l_tap), .word_o(l_word), .word_end_o(l_end), .wr_stb_o(l_stb)
  );

  sr_word_assembler tail_i (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .casc_en(l_tap[0]),
    .len_sel(1'b0), .nxt_word(c_nxt), .full_i(full_i),
    .tap_o(t_tap), .word_o(t_word), .word_end_o(t_end), .wr_stb_o(t_stb)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // R2, R10: reset behaviour and release latency
  task automatic do_reset();
    rst_n = 1'b0; ser_in = 1'b1; full_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 taps in reset", 32'(tap_o), 32'h0);
    chk("R2 end/stb in reset", 32'({word_end_o, wr_stb_o}), 32'h0);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R10 nothing stored during release", 32'(word_o), 32'h0);
  endtask

  // Shift n bits into dut_i, checking taps and strobe along the way
  task automatic send(input int n, input logic [15:0] d, input logic exp_stb);
    for (int i = 0; i < n; i++) begin
      ser_in = d[i];
      @(posedge clk); @(negedge clk);
      if (i == 0) chk("R3 taps low on first edge", 32'(tap_o), 32'h0);
      if (i == 7) chk("R3 bit-7 tap only", 32'(tap_o), 32'h1);
      chk("R6 strobe timing", 32'(wr_stb_o), 32'((i == n - 1) && exp_stb));
    end
  endtask

  task automatic t_nine();
    casc_en = 1'b1; len_sel = 1'b1; do_reset();
    send(9, 16'h01A5, 1'b1);
    chk("R1 nine-bit word", 32'(word_o), 32'h1A5);
    chk("R4 nine-bit taps", 32'({tap_o, word_end_o}), 32'h7);
    send(9, 16'h00F3, 1'b1);
    chk("R5 back-to-back word", 32'(word_o), 32'h0F3);
  endtask

  task automatic t_eight();
    casc_en = 1'b1; len_sel = 1'b1; do_reset();
    send(9, 16'h01FF, 1'b1);
    len_sel = 1'b0;
    send(8, 16'h00C3, 1'b1);
    chk("R5 eight-bit word, bit 8 cleared", 32'(word_o), 32'h0C3);
    chk("R4 eight-bit end", 32'({tap_o, word_end_o}), 32'h3);
    send(8, 16'h005A, 1'b1);
    chk("R1 second eight-bit word", 32'(word_o), 32'h05A);
  endtask

  task automatic t_full();
    casc_en = 1'b1; len_sel = 1'b1; do_reset();
    full_i = 1'b1;
    send(9, 16'h0133, 1'b0);
    chk("R7 no strobe while full", 32'(wr_stb_o), 32'h0);
    full_i = 1'b0;
    send(9, 16'h00CC, 1'b1);
    chk("R7 next word after full", 32'(word_o), 32'h0CC);
  endtask

  task automatic t_gate();
    casc_en = 1'b0; len_sel = 1'b1; do_reset();
    ser_in = 1'b1;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    chk("R8 gated word unchanged", 32'(word_o), 32'h0);
    chk("R8 gated taps unchanged", 32'(tap_o), 32'h0);
    casc_en = 1'b1;
    send(9, 16'h0155, 1'b1);
    chk("R8 stores from bit 0 after enable", 32'(word_o), 32'h155);
    casc_en = 1'b1;
  endtask

  task automatic t_chain();
    logic [15:0] d [2];
    d[0] = 16'hB4E1; d[1] = 16'h3C5A;
    casc_en = 1'b1; len_sel = 1'b1; do_reset();
    for (int w = 0; w < 2; w++) begin
      for (int i = 0; i < 16; i++) begin
        ser_in = d[w][i];
        @(posedge clk); @(negedge clk);
        if (i == 14) chk("R9 no early chain strobe", 32'(t_stb), 32'h0);
      end
      chk("R9 chained strobe", 32'(t_stb), 32'h1);
      chk("R9 chained 16-bit word", 32'({t_word[7:0], l_word[7:0]}), 32'(d[w]));
    end
  endtask

  initial begin
    rst_n = 1'b0; ser_in = 1'b0; casc_en = 1'b1; len_sel = 1'b1; full_i = 1'b0;
    t_nine();
    t_eight();
    t_full();
    t_gate();
    t_chain();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule